// File: doc/BRIEF.md
# Per-Processor Address Translator

This block sits beside one processing element and turns the block-relative virtual addresses it issues into physical addresses in a shared on-chip memory. The shared memory is cut into equal blocks of 2^OFS_W bytes (16 KB by default). A virtual address therefore has two parts. The low OFS_W bits are an offset and pass through unchanged. The bits above them are a virtual block index. That index selects one entry of a small map table, and the entry supplies a physical block index.

Each map entry also records how this element was granted the block. The three grant kinds are:
- exclusive ownership;
- ownership with read/write rights while other elements may share the block read-only;
- read-only sharing of a block that another element owns.

A lookup is registered. In the cycle after a request, the block returns either a translated address or a one-cycle fault. A fault is raised when the entry is not valid, or when the access type is not allowed by the recorded grant. A separate update port lets the memory allocator install entries when it grants blocks and clear them when it frees blocks. A chip has one instance of this block per processing element, so the same physical block may appear at different virtual indices in different instances, or at several indices in one instance.

Top module: `xlat_top`

## Requirements
- R1: While reset is low, and after it is released, rsp_valid, rsp_fault and rsp_paddr are all 0, and every map entry is invalid: any lookup after reset faults until an entry is written.
- R2: A granted lookup returns rsp_paddr = {physical block index, req_vaddr[OFS_W-1:0]}, with OFS_W = 14, so the offset bits pass through untouched.
- R3: A request sampled on a clock edge produces its response on the next edge. Exactly one of rsp_valid or rsp_fault is high for one cycle, and neither is high in a cycle that follows no request.
- R4: Mode code 0 (exclusive) grants both reads and writes.
- R5: Mode code 1 (owner read/write, others may share) grants both reads and writes.
- R6: Mode code 2 (read-only sharer) grants reads. A write (req_write = 1) faults.
- R7: Mode code 3 is reserved, and any access to an entry holding it faults.
- R8: A lookup of an entry that is not valid faults. An update with upd_valid = 0 makes the entry invalid.
- R9: An update written on one edge is used by lookups sampled from the next edge on. A lookup sampled on the same edge as an update to the same index sees the old entry.
- R10: Several virtual indices may map to the same physical block, and each translates independently.
- R11: Whenever rsp_valid is 0, rsp_paddr is 0. In particular, a fault returns no translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Write one map entry this cycle |
| upd_vidx | input | VBLK_W (6) | Virtual block index of the entry written |
| upd_pidx | input | PBLK_W (8) | Physical block index stored |
| upd_mode | input | 2 | Grant kind: 0 exclusive, 1 owner read/write, 2 read-only sharer, 3 reserved |
| upd_valid | input | 1 | 1 installs the mapping, 0 clears it |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | VBLK_W+OFS_W (20) | Virtual address |
| rsp_valid | output | 1 | Translated address available |
| rsp_fault | output | 1 | Request refused |
| rsp_paddr | output | PBLK_W+OFS_W (22) | Physical address, 0 unless rsp_valid |

## Verification
The properties assume that req_valid and upd_en are low while reset is asserted. They also assume that no second update to an index arrives between the update they reason about and the lookup one cycle later. The bench meets both assumptions:
- It drives all inputs on falling edges.
- It holds requests low during every reset.
- It issues updates and lookups as separate single-cycle operations.

The one deliberate exception is the same-cycle collision test. That test checks only the stale-entry rule, which no property depends on.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        MODE_EXCL     = 2'd0,
        MODE_OWN_RW   = 2'd1,
        MODE_RD_SHARE = 2'd2,
        MODE_RSVD     = 2'd3
    } acc_mode_t;

endpackage

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
#(
    parameter int VBLK_W = 6,
    parameter int PBLK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [VBLK_W-1:0] wr_idx,
    input  logic [PBLK_W-1:0] wr_pidx,
    input  acc_mode_t         wr_mode,
    input  logic              wr_valid,
    input  logic [VBLK_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [PBLK_W-1:0] rd_pidx,
    output acc_mode_t         rd_mode
);
    localparam int ENTRIES = 1 << VBLK_W;

    logic [ENTRIES-1:0] valid_q;
    logic [PBLK_W-1:0]  pidx_q [ENTRIES];
    acc_mode_t          mode_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                pidx_q[i] <= '0;
                mode_q[i] <= MODE_EXCL;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            pidx_q[wr_idx]  <= wr_pidx;
            mode_q[wr_idx]  <= wr_mode;
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_pidx  = pidx_q[rd_idx];
        rd_mode  = mode_q[rd_idx];
    end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  logic      entry_valid,
    input  acc_mode_t entry_mode,
    input  logic      is_write,
    output logic      grant
);
    logic mode_ok;

    always_comb begin
        unique case (entry_mode)
            MODE_EXCL:     mode_ok = 1'b1;
            MODE_OWN_RW:   mode_ok = 1'b1;
            MODE_RD_SHARE: mode_ok = !is_write;
            MODE_RSVD:     mode_ok = 1'b0;
            default:       mode_ok = 1'b0;
        endcase
        grant = entry_valid && mode_ok;
    end
endmodule

// File: rtl/xlat_top.sv
module xlat_top
    import xlat_pkg::*;
#(
    parameter int VBLK_W   = 6,
    parameter int NUM_PBLK = 256,
    parameter int OFS_W    = 14,
    localparam int PBLK_W  = $clog2(NUM_PBLK),
    localparam int VA_W    = VBLK_W + OFS_W,
    localparam int PA_W    = PBLK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [VBLK_W-1:0] upd_vidx,
    input  logic [PBLK_W-1:0] upd_pidx,
    input  logic [1:0]        upd_mode,
    input  logic              upd_valid,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr
);
    logic              ent_valid;
    logic [PBLK_W-1:0] ent_pidx;
    acc_mode_t         ent_mode;
    logic              grant;

    xlat_table #(.VBLK_W(VBLK_W), .PBLK_W(PBLK_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_en),
        .wr_idx   (upd_vidx),
        .wr_pidx  (upd_pidx),
        .wr_mode  (acc_mode_t'(upd_mode)),
        .wr_valid (upd_valid),
        .rd_idx   (req_vaddr[VA_W-1:OFS_W]),
        .rd_valid (ent_valid),
        .rd_pidx  (ent_pidx),
        .rd_mode  (ent_mode)
    );

    xlat_perm u_perm (
        .entry_valid (ent_valid),
        .entry_mode  (ent_mode),
        .is_write    (req_write),
        .grant       (grant)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid && grant;
            rsp_fault <= req_valid && !grant;
            rsp_paddr <= (req_valid && grant) ? {ent_pidx, req_vaddr[OFS_W-1:0]} : '0;
        end
    end
endmodule

// File: rtl/xlat_top_chk.sv
module xlat_top_chk #(
    parameter int VBLK_W = 6,
    parameter int PBLK_W = 8,
    parameter int OFS_W  = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     upd_en,
    input logic [VBLK_W-1:0]        upd_vidx,
    input logic [1:0]               upd_mode,
    input logic                     upd_valid,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [VBLK_W+OFS_W-1:0]  req_vaddr,
    input logic                     rsp_valid,
    input logic                     rsp_fault,
    input logic [PBLK_W+OFS_W-1:0]  rsp_paddr
);
    // R3: a request yields exactly one outcome on the next edge
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid ^ rsp_fault));

    // R3: no response without a request
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault));

    // R2: offset passes through
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_valid || rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));

    // R11: no address unless granted
    a_r11_zero_paddr: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0));

    // R6: a write right after a read-only install of the same index faults
    a_r6_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && $past(upd_en && upd_valid && upd_mode == 2'd2)
         && $past(upd_vidx) == req_vaddr[VBLK_W+OFS_W-1:OFS_W]) |=> rsp_fault);

    // R8: a lookup right after clearing that index faults
    a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(upd_en && !upd_valid)
         && $past(upd_vidx) == req_vaddr[VBLK_W+OFS_W-1:OFS_W]) |=> rsp_fault);
endmodule

bind xlat_top xlat_top_chk #(.VBLK_W(VBLK_W), .PBLK_W(PBLK_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .upd_vidx  (upd_vidx),
    .upd_mode  (upd_mode),
    .upd_valid (upd_valid),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/xlat_top_test.sv
module xlat_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int VBLK_W = 6;
    localparam int PBLK_W = 8;
    localparam int OFS_W  = 14;
    localparam int PA_W   = PBLK_W + OFS_W;
    localparam int NVEC   = 13;

    // {req tag[4], vidx[6], write[1], offset[14], ok[1], pidx[8]}
    localparam logic [33:0] VEC [NVEC] = '{
        {4'd4,  6'd1,  1'b0, 14'h0000, 1'b1, 8'h12}, // R4 read exclusive
        {4'd4,  6'd1,  1'b1, 14'h3FFF, 1'b1, 8'h12}, // R4 write exclusive
        {4'd5,  6'd2,  1'b0, 14'h1234, 1'b1, 8'h34}, // R5 read owner
        {4'd5,  6'd2,  1'b1, 14'h0ABC, 1'b1, 8'h34}, // R5 write owner
        {4'd6,  6'd3,  1'b0, 14'h2001, 1'b1, 8'h56}, // R6 read sharer
        {4'd6,  6'd3,  1'b1, 14'h2001, 1'b0, 8'h00}, // R6 write sharer faults
        {4'd7,  6'd6,  1'b0, 14'h0001, 1'b0, 8'h00}, // R7 reserved read
        {4'd7,  6'd6,  1'b1, 14'h0001, 1'b0, 8'h00}, // R7 reserved write
        {4'd10, 6'd7,  1'b0, 14'h0777, 1'b1, 8'h12}, // R10 alias of block 0x12
        {4'd2,  6'd63, 1'b1, 14'h3FFF, 1'b1, 8'h00}, // R2 top index, full offset
        {4'd2,  6'd4,  1'b0, 14'h2AAA, 1'b1, 8'hFF}, // R2 top physical block
        {4'd8,  6'd10, 1'b0, 14'h0000, 1'b0, 8'h00}, // R8 never written
        {4'd8,  6'd0,  1'b1, 14'h0100, 1'b0, 8'h00}  // R8 never written
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_en = 1'b0;
    logic [VBLK_W-1:0] upd_vidx = '0;
    logic [PBLK_W-1:0] upd_pidx = '0;
    logic [1:0]        upd_mode = '0;
    logic              upd_valid = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [VBLK_W+OFS_W-1:0] req_vaddr = '0;
    logic              rsp_valid;
    logic              rsp_fault;
    logic [PA_W-1:0]   rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_top uut (
        .clk(clk), .rst_n(rst_n),
        .upd_en(upd_en), .upd_vidx(upd_vidx), .upd_pidx(upd_pidx),
        .upd_mode(upd_mode), .upd_valid(upd_valid),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input logic [PA_W+1:0] act, input logic [PA_W+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {valid,fault,paddr}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic update(input int vidx, input int pidx, input int mode, input bit vld);
        upd_en = 1'b1; upd_vidx = VBLK_W'(vidx); upd_pidx = PBLK_W'(pidx);
        upd_mode = 2'(mode); upd_valid = vld;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic lookup(input int vidx, input bit wr, input int ofs);
        req_valid = 1'b1; req_write = wr;
        req_vaddr = {VBLK_W'(vidx), OFS_W'(ofs)};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [PA_W+1:0] expect_ok(input int pidx, input int ofs);
        return {1'b1, 1'b0, PBLK_W'(pidx), OFS_W'(ofs)};
    endfunction

    localparam logic [PA_W+1:0] EXP_FAULT = {1'b0, 1'b1, {PA_W{1'b0}}};
    localparam logic [PA_W+1:0] EXP_IDLE  = '0;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs during reset", {rsp_valid, rsp_fault, rsp_paddr}, EXP_IDLE);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {rsp_valid, rsp_fault, rsp_paddr}, EXP_IDLE);
        lookup(1, 0, 5);
        check("R1 entry invalid after reset", {rsp_valid, rsp_fault, rsp_paddr}, EXP_FAULT);

        update(1, 'h12, 0, 1);
        update(2, 'h34, 1, 1);
        update(3, 'h56, 2, 1);
        update(6, 'hFF, 3, 1);
        update(7, 'h12, 0, 1);
        update(63, 'h00, 1, 1);
        update(4, 'hFF, 0, 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [33:0] v;
            v = VEC[i];
            lookup(int'(v[29:24]), v[23], int'(v[22:9]));
            check($sformatf("R%0d vector %0d", v[33:30], i),
                  {rsp_valid, rsp_fault, rsp_paddr},
                  v[8] ? expect_ok(int'(v[7:0]), int'(v[22:9])) : EXP_FAULT);
        end

        // R3: idle cycle after responses gives nothing
        @(negedge clk);
        check("R3 no response without request", {rsp_valid, rsp_fault, rsp_paddr}, EXP_IDLE);

        // R9: update takes effect next cycle
        update(20, 'hA5, 1, 1);
        lookup(20, 1, 'h0042);
        check("R9 update visible next cycle", {rsp_valid, rsp_fault, rsp_paddr}, expect_ok('hA5, 'h0042));

        // R9: same-cycle collision uses old entry
        upd_en = 1'b1; upd_vidx = 6'd20; upd_pidx = 8'h5A; upd_mode = 2'd1; upd_valid = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_vaddr = {6'd20, 14'h0010};
        @(negedge clk);
        upd_en = 1'b0; req_valid = 1'b0;
        check("R9 same-cycle lookup sees old entry", {rsp_valid, rsp_fault, rsp_paddr}, expect_ok('hA5, 'h0010));
        lookup(20, 0, 'h0010);
        check("R9 new entry afterwards", {rsp_valid, rsp_fault, rsp_paddr}, expect_ok('h5A, 'h0010));

        // R6: entry downgraded to read-only, write right after faults
        update(20, 'h5A, 2, 1);
        lookup(20, 1, 'h0001);
        check("R6 write after read-only install", {rsp_valid, rsp_fault, rsp_paddr}, EXP_FAULT);

        // R8: clearing an entry
        update(1, 'h12, 0, 0);
        lookup(1, 0, 'h0003);
        check("R8 cleared entry faults", {rsp_valid, rsp_fault, rsp_paddr}, EXP_FAULT);
        lookup(7, 0, 'h0003);
        check("R10 alias survives clear of other index", {rsp_valid, rsp_fault, rsp_paddr}, expect_ok('h12, 'h0003));

        // R11: fault response carries zero address; then idle
        lookup(6, 0, 'h3FFF);
        check("R11 fault has zero paddr", {rsp_valid, rsp_fault, rsp_paddr}, EXP_FAULT);

        // R1: mid-run reset clears the table
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 outputs in mid-run reset", {rsp_valid, rsp_fault, rsp_paddr}, EXP_IDLE);
        rst_n = 1'b1;
        @(negedge clk);
        lookup(2, 0, 'h0004);
        check("R1 table cleared by reset", {rsp_valid, rsp_fault, rsp_paddr}, EXP_FAULT);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule